// File: doc/BRIEF.md
# Flash Status-Register Write-Protection Controller

This block makes the protection decisions for the command engine of a serial flash device. It holds a status byte with three fields: a write-lock bit, a three-bit block-protect level and a write-enable latch. It also samples an external active-low write-protect pin. Each cycle the command decoder may raise one strobe: write enable, status write, page program, sector erase or bulk erase. The block answers every strobe except write enable with a one-cycle accept or reject pulse. It also reports the current protection mode.

When the lock bit is set and the pin is low, the status byte is frozen. This hardware-protected state begins whenever the second of those two conditions becomes true, in either order. It ends only when the pin is raised. The block-protect level selects a run of top sectors that refuse program and erase in every mode. Serial shifting, the array itself and program or erase timing belong to other blocks.

Top module: `sr_protect_ctl`

## Requirements
- R1: After reset the status byte reads 0x00, mode_o is 0, and acc_o and rej_o are low.
- R2: A write-enable strobe sets the latch, which is status bit 1, from the next cycle on.
- R3: With the lock bit (status bit 7) at 0, a status write is accepted exactly when the latch is set, whatever the pin level. An accepted write loads bits 7 and 4:2 from sr_data_i. Bits 6:5 and 0 read as 0, and bit 1 comes only from the latch.
- R4: With the lock bit at 1 and the synchronized pin high, a status write is accepted exactly when the latch is set.
- R5: With the lock bit at 1 and the synchronized pin low, every status write is rejected and bits 7 and 4:2 keep their value. The pin reaches the logic through SYNC_STAGES flops (default 2).
- R6: Hardware protection (mode 2) is entered in both orders: the lock bit written to 1 while the pin is low, or the pin driven low while the lock bit is 1. It is left only by driving the pin high, and the lock bit keeps its value when that happens.
- R7: With block-protect level bp (status bits 4:2) nonzero, the top min(16, 2^(bp-1)) of the 16 sectors are protected. The sector is the top 4 address bits. Page program and sector erase are accepted exactly when the latch is set and the sector is not protected. This holds in both software and hardware protection.
- R8: Bulk erase is accepted exactly when the latch is set and bp is 0.
- R9: Every accepted or rejected status write, program or erase clears the latch, in the same cycle as its outcome pulse.
- R10: The outcome of a strobe appears on acc_o or rej_o, never both, in the cycle after the strobe. mode_o is 2 in hardware protection, otherwise 1 when bp is nonzero, otherwise 0.
- R11: If several strobes arrive together, only one is executed, in the priority status write, program, sector erase, bulk erase, write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | Write-protect pin, active low, asynchronous |
| wren_i | input | 1 | Write-enable command strobe |
| wrsr_i | input | 1 | Status write command strobe |
| prog_i | input | 1 | Page program command strobe |
| serase_i | input | 1 | Sector erase command strobe |
| berase_i | input | 1 | Bulk erase command strobe |
| addr_i | input | ADDR_W | Target byte address for program and sector erase |
| sr_data_i | input | 8 | New status byte for a status write |
| status_o | output | 8 | Current status byte |
| acc_o | output | 1 | Command accepted, one-cycle pulse |
| rej_o | output | 1 | Command rejected, one-cycle pulse |
| mode_o | output | 2 | Protection mode: 0 open, 1 software, 2 hardware |

## Verification
The assertions check on every cycle the following properties. A status write in mode 2 or without the latch is rejected. A rejection leaves the lock and protect fields unchanged. Any outcome pulse leaves the latch clear, and a nonzero protect level blocks bulk erase. Accept and reject never coincide, and mode 2 always comes with the lock bit set.

Only the bench's scenarios can show the rest. These are the sector boundary for each protect level and the pin being ignored while the lock bit is clear. They also cover entering hardware protection in both orders and leaving it through the pin alone, and the choice among simultaneous strobes.

// File: rtl/sr_protect_pkg.sv
package sr_protect_pkg;

    localparam int SR_W = 8;

    // Status byte layout: lock at 7, protect level at 4:2, latch at 1
    typedef struct packed {
        logic       lock;
        logic [1:0] spare;
        logic [2:0] bp;
        logic       wel;
        logic       busy;
    } sr_t;

    typedef enum logic [1:0] {
        MODE_OPEN = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_HARD = 2'd2
    } pmode_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WREN   = 3'd1,
        OP_WRSR   = 3'd2,
        OP_PROG   = 3'd3,
        OP_SERASE = 3'd4,
        OP_BERASE = 3'd5
    } op_e;

    // One command per cycle; status write has the highest priority
    function automatic op_e pick_op(input logic wren, input logic wrsr,
                                    input logic prog, input logic se,
                                    input logic be);
        if (wrsr)      return OP_WRSR;
        else if (prog) return OP_PROG;
        else if (se)   return OP_SERASE;
        else if (be)   return OP_BERASE;
        else if (wren) return OP_WREN;
        else           return OP_NONE;
    endfunction

    // Upper 2^(bp-1) sectors guarded, capped at the whole array
    function automatic logic sector_locked(input logic [2:0] bp,
                                           input int unsigned sec,
                                           input int unsigned nsec);
        int unsigned span;
        if (bp == 3'd0) return 1'b0;
        span = 32'd1 << (int'(bp) - 1);
        if (span >= nsec) return 1'b1;
        return (sec >= nsec - span);
    endfunction

    function automatic pmode_e mode_of(input sr_t s, input logic pin_low);
        if (s.lock && pin_low) return MODE_HARD;
        else if (s.bp != 3'd0) return MODE_SOFT;
        else                   return MODE_OPEN;
    endfunction

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic low_o
);
    logic [STAGES-1:0] shr;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) shr[0] <= 1'b1;
                    else     shr[0] <= pin_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) shr[i] <= 1'b1;
                    else     shr[i] <= shr[i-1];
                end
            end
        end
    endgenerate

    assign low_o = ~shr[STAGES-1];
endmodule

// File: rtl/region_check.sv
module region_check
    import sr_protect_pkg::*;
#(
    parameter int SECTORS = 16,
    localparam int SEC_W  = $clog2(SECTORS)
) (
    input  logic [2:0]       bp_i,
    input  logic [SEC_W-1:0] sector_i,
    output logic             locked_o
);
    always_comb begin
        locked_o = sector_locked(bp_i, int'(32'(sector_i)), SECTORS);
    end
endmodule

// File: rtl/sr_core.sv
module sr_core
    import sr_protect_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  op_e             op_i,
    input  logic [SR_W-1:0] data_i,
    input  logic            pin_low_i,
    input  logic            region_locked_i,
    output sr_t             sr_o,
    output logic            acc_o,
    output logic            rej_o
);
    sr_t  sr_q;
    sr_t  wr_val;
    logic grant;
    logic judged;

    assign wr_val = sr_t'(data_i);

    always_comb begin
        grant  = 1'b0;
        judged = 1'b1;
        unique case (op_i)
            OP_WRSR:             grant = sr_q.wel && !(sr_q.lock && pin_low_i);
            OP_PROG, OP_SERASE:  grant = sr_q.wel && !region_locked_i;
            OP_BERASE:           grant = sr_q.wel && (sr_q.bp == 3'd0);
            default:             judged = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            acc_o <= 1'b0;
            rej_o <= 1'b0;
        end else begin
            acc_o <= judged && grant;
            rej_o <= judged && !grant;
            if (op_i == OP_WREN) sr_q.wel <= 1'b1;
            if (judged) sr_q.wel <= 1'b0;
            if (op_i == OP_WRSR && grant) begin
                sr_q.lock <= wr_val.lock;
                sr_q.bp   <= wr_val.bp;
            end
        end
    end

    assign sr_o = sr_q;
endmodule

// File: rtl/sr_protect_ctl.sv
module sr_protect_ctl
    import sr_protect_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int SECTORS     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              wrsr_i,
    input  logic              prog_i,
    input  logic              serase_i,
    input  logic              berase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        sr_data_i,
    output logic [7:0]        status_o,
    output logic              acc_o,
    output logic              rej_o,
    output logic [1:0]        mode_o
);
    localparam int SEC_W = $clog2(SECTORS);

    logic             pin_low;
    logic             locked;
    op_e              op;
    sr_t              sr;
    logic [SEC_W-1:0] sector;

    assign op     = pick_op(wren_i, wrsr_i, prog_i, serase_i, berase_i);
    assign sector = addr_i[ADDR_W-1 -: SEC_W];

    wp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_n_i (wp_n_i),
        .low_o   (pin_low)
    );

    region_check #(.SECTORS(SECTORS)) u_region (
        .bp_i     (sr.bp),
        .sector_i (sector),
        .locked_o (locked)
    );

    sr_core u_core (
        .clk             (clk),
        .rst             (rst),
        .op_i            (op),
        .data_i          (sr_data_i),
        .pin_low_i       (pin_low),
        .region_locked_i (locked),
        .sr_o            (sr),
        .acc_o           (acc_o),
        .rej_o           (rej_o)
    );

    assign status_o = sr;
    assign mode_o   = mode_of(sr, pin_low);
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk (
    input logic       clk,
    input logic       rst,
    input logic       wrsr_i,
    input logic       prog_i,
    input logic       serase_i,
    input logic       berase_i,
    input logic [7:0] status_o,
    input logic       acc_o,
    input logic       rej_o,
    input logic [1:0] mode_o
);
    // R9
    wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_o || rej_o) |-> !status_o[1]);

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        rej_o |-> (status_o[7:2] == $past(status_o[7:2])));

    // R5
    hard_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2 && wrsr_i) |=> rej_o);

    // R3
    wel_needed_chk: assert property (@(posedge clk) disable iff (rst)
        ((wrsr_i || prog_i || serase_i || berase_i) && !status_o[1]) |=> rej_o);

    // R8
    bulk_chk: assert property (@(posedge clk) disable iff (rst)
        (berase_i && !wrsr_i && !prog_i && !serase_i && status_o[4:2] != 3'd0) |=> rej_o);

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_o && rej_o) && mode_o != 2'd3);

    // R6
    hard_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> status_o[7]);
endmodule

bind sr_protect_ctl sr_protect_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wrsr_i   (wrsr_i),
    .prog_i   (prog_i),
    .serase_i (serase_i),
    .berase_i (berase_i),
    .status_o (status_o),
    .acc_o    (acc_o),
    .rej_o    (rej_o),
    .mode_o   (mode_o)
);

// File: tb/sim_sr_protect_ctl.sv
module sim_sr_protect_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_n = 1'b1;
    logic        wren = 0, wrsr = 0, prog = 0, serase = 0, berase = 0;
    logic [19:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  status;
    logic        acc, rej;
    logic [1:0]  mode;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sr_protect_ctl u0 (
        .clk(clk), .rst(rst), .wp_n_i(wp_n),
        .wren_i(wren), .wrsr_i(wrsr), .prog_i(prog),
        .serase_i(serase), .berase_i(berase),
        .addr_i(addr), .sr_data_i(din),
        .status_o(status), .acc_o(acc), .rej_o(rej), .mode_o(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mask bits: 4 wrsr, 3 prog, 2 serase, 1 berase, 0 wren
    task automatic pulse(input logic [4:0] m, input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        {wrsr, prog, serase, berase, wren} = m;
        addr = a;
        din  = d;
        @(negedge clk);
        {wrsr, prog, serase, berase, wren} = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_mode(input bit lk, input bit pin, input int bp);
        if (lk && !pin) return 2;
        return (bp != 0) ? 1 : 0;
    endfunction

    function automatic bit prot(input int bp, input int sec);
        int span;
        if (bp == 0) return 0;
        span = 1 << (bp - 1);
        if (span >= 16) return 1;
        return sec >= 16 - span;
    endfunction

    task automatic set_state(input bit lk, input int bp, input bit pin);
        wp_n = 1'b1;
        idle(4);
        pulse(5'b00001, '0, '0);
        pulse(5'b10000, '0, {lk, 2'b00, 3'(bp), 2'b00});
        wp_n = pin;
        idle(4);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1
        chk("R1 status", status, 8'h00);
        chk("R1 mode", mode, 0);
        chk("R1 pulses", {acc, rej}, 0);
        // R2
        pulse(5'b00001, '0, '0);
        chk("R2 latch", status, 8'h02);
        chk("R2 no pulse", {acc, rej}, 0);

        // R3 R4 R5: status-write sweep
        for (int lk = 0; lk < 2; lk++)
            for (int pin = 0; pin < 2; pin++)
                for (int wel = 0; wel < 2; wel++)
                    for (int bp = 0; bp < 8; bp++) begin
                        bit ok;
                        logic [7:0] nd, ex;
                        set_state(lk[0], bp, pin[0]);
                        chk("R10 mode", mode, exp_mode(lk[0], pin[0], bp));
                        if (wel != 0) pulse(5'b00001, '0, '0);
                        nd = {~lk[0], 2'b11, 3'(bp) ^ 3'b101, 2'b11};
                        ok = (wel != 0) && !(lk != 0 && pin == 0);
                        ex = ok ? {~lk[0], 2'b00, 3'(bp) ^ 3'b101, 2'b00}
                                : {lk[0], 2'b00, 3'(bp), 2'b00};
                        pulse(5'b10000, '0, nd);
                        if (lk == 0)      chk("R3 outcome", {acc, rej}, {ok, !ok});
                        else if (pin != 0) chk("R4 outcome", {acc, rej}, {ok, !ok});
                        else              chk("R5 outcome", {acc, rej}, {ok, !ok});
                        chk("R9 R3 status", status, ex);
                    end

        // R7 R8: array sweep, software then hardware protection
        for (int hard = 0; hard < 2; hard++)
            for (int bp = 0; bp < 8; bp++) begin
                set_state(hard[0], bp, !hard[0]);
                chk("R10 mode", mode, hard != 0 ? 2 : (bp != 0 ? 1 : 0));
                for (int sec = 0; sec < 16; sec++)
                    for (int wel = 0; wel < 2; wel++)
                        for (int op = 0; op < 2; op++) begin
                            bit ok;
                            if (wel != 0) pulse(5'b00001, '0, '0);
                            ok = (wel != 0) && !prot(bp, sec);
                            pulse(op == 0 ? 5'b01000 : 5'b00100,
                                  {4'(sec), 16'h5a5a}, 8'hff);
                            chk("R7 outcome", {acc, rej}, {ok, !ok});
                            chk("R9 latch", status[1], 0);
                        end
                for (int wel = 0; wel < 2; wel++) begin
                    bit ok;
                    if (wel != 0) pulse(5'b00001, '0, '0);
                    ok = (wel != 0) && bp == 0;
                    pulse(5'b00010, '0, '0);
                    chk("R8 outcome", {acc, rej}, {ok, !ok});
                end
            end

        // R6: pin low first, then lock written
        set_state(1'b0, 0, 1'b0);
        chk("R3 pin ignored mode", mode, 0);
        pulse(5'b00001, '0, '0);
        pulse(5'b10000, '0, 8'h88);
        chk("R6 write accepted", {acc, rej}, 2'b10);
        chk("R6 enter mode", mode, 2);
        pulse(5'b00001, '0, '0);
        pulse(5'b10000, '0, 8'h00);
        chk("R6 still frozen", status, 8'h88);
        chk("R6 still hard", mode, 2);
        wp_n = 1'b1;
        idle(4);
        chk("R6 exit mode", mode, 1);
        chk("R6 lock kept", status, 8'h88);
        wp_n = 1'b0;
        idle(4);
        chk("R6 re-enter by pin", mode, 2);

        // R11: simultaneous strobes
        set_state(1'b0, 0, 1'b1);
        pulse(5'b01001, '0, '0);
        chk("R11 prog wins", {acc, rej}, 2'b01);
        chk("R11 wren dropped", status, 8'h00);
        pulse(5'b00001, '0, '0);
        pulse(5'b11111, '0, 8'h04);
        chk("R11 wrsr wins", {acc, rej}, 2'b10);
        chk("R11 wrsr data", status, 8'h04);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule